// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Coherent Byte Readout

This block keeps a 12-bit count that advances on every clock edge where a 1 MHz enable is high. The count therefore measures time in microseconds. Firmware cannot load the count or stop it. Firmware times an event by taking one reading at the start and another at the end. The modulo-4096 difference of the two readings is the elapsed time in microseconds, and this holds even when the count wraps from 0xFFF to 0x000 between the readings.

The data path to firmware is eight bits wide, so a reading takes two accesses.

- A low-byte read returns the live bits [7:0]. On the same clock edge it copies the live upper four bits into a shadow register.
- A later high-nibble read returns the shadow register, not the live count.

The two halves of a reading therefore always come from one instant. Read data appears on `rd_data_o` one clock after the strobe and stays there until the next strobe.

Two taps on the count produce one-cycle tick pulses for interrupt edge detection:

- The fast tick comes from bit 6, so it has a 128 µs period.
- The slow tick comes from bit 9, so it has a 1.024 ms period.

Top module: `usec_timer`

## Requirements
- R1: After reset the count, the shadow register and `rd_data_o` are all zero, and both tick outputs are low. A high-nibble read issued before any low-byte read returns 0x00.
- R2: The count increases by one on each clock edge where `us_en_i` is high. It keeps its value on edges where `us_en_i` is low.
- R3: The count wraps from 0xFFF to 0x000 with no flag. The difference of two readings, taken modulo 4096, equals the number of enabled edges between the two low-byte captures, including across a wrap.
- R4: When `rd_lo_i` is high on an edge, `rd_data_o` shows count bits [7:0] from that edge, starting one cycle later. On the same edge the shadow register takes count bits [11:8].
- R5: When `rd_hi_i` is high on an edge and `rd_lo_i` is low, `rd_data_o` shows the shadow value in bits [3:0] and zero in bits [7:4], starting one cycle later. The live count does not affect this value.
- R6: When `rd_lo_i` and `rd_hi_i` are both high on the same edge, the low-byte read takes effect, including its capture into the shadow register.
- R7: `rd_data_o` holds its value on every edge where neither strobe is high.
- R8: `tick_fast_o` is high for exactly one cycle after the count bit 6 changes from 0 to 1, that is, when count bits [6:0] become 64. It is low at all other times.
- R9: `tick_slow_o` is high for exactly one cycle after the count bit 9 changes from 0 to 1, that is, when count bits [9:0] become 512. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_en_i | input | 1 | One-cycle enable at 1 MHz that advances the count |
| rd_lo_i | input | 1 | Strobe: read low byte and capture the upper nibble |
| rd_hi_i | input | 1 | Strobe: read the captured upper nibble |
| rd_data_o | output | 8 | Read data, valid from the cycle after a strobe |
| tick_fast_o | output | 1 | One-cycle pulse every 128 counts |
| tick_slow_o | output | 1 | One-cycle pulse every 1024 counts |

## Verification
A table of enable runs and gaps drives the counter through fixed end points, and each end point is read back through the two-access protocol. The run lengths are chosen so that a dropped, doubled or ungated increment changes the result. Two readings taken while the count runs across the 0xFFF wrap show whether the modulo difference still gives the elapsed time. A high-nibble read issued hundreds of counts after its low-byte read shows whether the shadow value or the live value is returned. A single cycle with both strobes high shows which strobe has priority. During a long run, first with the enable held high and then with it toggling every cycle, each tick output is compared cycle by cycle against a reference count. This shows whether a pulse fires on the correct bit edge and whether it is suppressed while the count holds.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CNT_W    = 12;
    localparam int LO_W     = 8;
    localparam int HI_W     = CNT_W - LO_W;
    localparam int NUM_TAPS = 2;
    localparam int FAST_TAP = 6;
    localparam int SLOW_TAP = 9;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    typedef struct packed {
        logic [LO_W-1:0] data;
        logic [HI_W-1:0] shadow;
    } rd_st_t;
endpackage

// File: rtl/ut_counter.sv
module ut_counter
    import timer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);
    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
endmodule

// File: rtl/ut_rise_tap.sv
module ut_rise_tap (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cur_i,
    input  logic nxt_i,
    output logic pulse_o
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = nxt_i & ~cur_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/ut_readport.sv
module ut_readport
    import timer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [LO_W-1:0]  data_o,
    output logic [HI_W-1:0]  shadow_o
);
    localparam int PAD_W = LO_W - HI_W;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_lo_i) begin
            st_d.data   = cnt_i[LO_W-1:0];
            st_d.shadow = cnt_i[CNT_W-1:LO_W];
        end else if (rd_hi_i) begin
            st_d.data   = {{PAD_W{1'b0}}, st_q.shadow};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o   = st_q.data;
    assign shadow_o = st_q.shadow;
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import timer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       us_en_i,
    input  logic       rd_lo_i,
    input  logic       rd_hi_i,
    output logic [7:0] rd_data_o,
    output logic       tick_fast_o,
    output logic       tick_slow_o
);
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    cnt_d;
    logic [HI_W-1:0]     shadow_q;
    logic [NUM_TAPS-1:0] tick;

    ut_counter u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (us_en_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TB = (g == 0) ? FAST_TAP : SLOW_TAP;
        ut_rise_tap u_tap (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cur_i   (cnt_q[TB]),
            .nxt_i   (cnt_d[TB]),
            .pulse_o (tick[g])
        );
    end

    ut_readport u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_lo_i  (rd_lo_i),
        .rd_hi_i  (rd_hi_i),
        .cnt_i    (cnt_q),
        .data_o   (rd_data_o),
        .shadow_o (shadow_q)
    );

    assign tick_fast_o = tick[0];
    assign tick_slow_o = tick[1];
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk
    import timer_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             us_en_i,
    input logic             rd_lo_i,
    input logic             rd_hi_i,
    input logic [7:0]       rd_data_o,
    input logic             tick_fast_o,
    input logic             tick_slow_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [HI_W-1:0]  shadow_q
);
    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        us_en_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    // R2
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !us_en_i |=> $stable(cnt_q));

    // R4
    lo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_lo_i |=> (rd_data_o == $past(cnt_q[LO_W-1:0]))
                 && (shadow_q == $past(cnt_q[CNT_W-1:LO_W])));

    // R5
    hi_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_hi_i && !rd_lo_i) |=> rd_data_o == {{(LO_W-HI_W){1'b0}}, $past(shadow_q)});

    // R7
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_lo_i && !rd_hi_i) |=> $stable(rd_data_o));

    // R8
    fast_tick_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_fast_o |-> cnt_q[FAST_TAP:0] == (FAST_TAP+1)'(1 << FAST_TAP));

    // R8
    fast_tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_fast_o |=> !tick_fast_o);

    // R9
    slow_tick_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_slow_o |-> cnt_q[SLOW_TAP:0] == (SLOW_TAP+1)'(1 << SLOW_TAP));
endmodule

bind usec_timer usec_timer_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .us_en_i     (us_en_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .rd_data_o   (rd_data_o),
    .tick_fast_o (tick_fast_o),
    .tick_slow_o (tick_slow_o),
    .cnt_q       (cnt_q),
    .shadow_q    (shadow_q)
);

// File: tb/usec_timer_tb.sv
`timescale 1ns/1ps
module usec_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic       tf, ts;

    int total = 0;
    int bad = 0;

    // reference count and its value before the last edge
    logic [11:0] m = '0;
    logic [11:0] mp = '0;

    always #2.5 clk = ~clk;

    usec_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .us_en_i     (en),
        .rd_lo_i     (rd_lo),
        .rd_hi_i     (rd_hi),
        .rd_data_o   (rd_data),
        .tick_fast_o (tf),
        .tick_slow_o (ts)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m  <= '0;
            mp <= '0;
        end else begin
            mp <= m;
            if (en) m <= m + 12'd1;
        end
    end

    typedef struct packed {
        logic [15:0] n;
        logic        en;
        logic [11:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'd100,  1'b1, 12'h064},
        '{16'd50,   1'b0, 12'h064},
        '{16'd300,  1'b1, 12'h190},
        '{16'd3000, 1'b1, 12'hD48},
        '{16'd696,  1'b1, 12'h000},
        '{16'd4095, 1'b1, 12'hFFF},
        '{16'd2,    1'b1, 12'h001},
        '{16'd255,  1'b1, 12'h100}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // full two-access read; snap is the reference count at the low-byte capture
    task automatic do_read(output logic [7:0] lo, output logic [7:0] hi,
                           output logic [11:0] snap);
        rd_lo = 1'b1;
        snap  = m;
        @(negedge clk);
        rd_lo = 1'b0;
        lo    = rd_data;
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        hi    = rd_data;
    endtask

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog R2: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  lo, hi, held;
        logic [11:0] snap, r1, r2;
        int          mis, frise, fcnt, srise, scnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(rd_data == 8'h00, "R1 data", rd_data, 0);
        chk(!tf && !ts, "R1 ticks", {tf, ts}, 0);
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        chk(rd_data == 8'h00, "R1 shadow", rd_data, 0);

        // R2 R3 R4 R5: table walk with known end points
        foreach (VECS[i]) begin
            en = VECS[i].en;
            repeat (int'(VECS[i].n)) @(negedge clk);
            en = 1'b0;
            do_read(lo, hi, snap);
            chk(lo == VECS[i].exp[7:0], "R2 lo", lo, VECS[i].exp[7:0]);
            chk(hi == {4'h0, VECS[i].exp[11:8]}, "R5 hi", hi, {4'h0, VECS[i].exp[11:8]});
        end

        // R6: both strobes in one cycle, count 0x100 -> 0x22C
        en = 1'b1;
        repeat (300) @(negedge clk);
        en = 1'b0;
        rd_lo = 1'b1;
        rd_hi = 1'b1;
        @(negedge clk);
        rd_lo = 1'b0;
        rd_hi = 1'b0;
        chk(rd_data == 8'h2C, "R6 lo wins", rd_data, 8'h2C);
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        chk(rd_data == 8'h02, "R6 shadow", rd_data, 8'h02);

        // R7: no strobe, running count, data holds
        held = rd_data;
        en = 1'b1;
        repeat (5) @(negedge clk);
        chk(rd_data == held, "R7 hold", rd_data, held);

        // R4 R5: shadow returned, not live, after 300 counts
        rd_lo = 1'b1;
        snap  = m;
        @(negedge clk);
        rd_lo = 1'b0;
        chk(rd_data == snap[7:0], "R4 lo", rd_data, snap[7:0]);
        repeat (300) @(negedge clk);
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        chk(rd_data == {4'h0, snap[11:8]}, "R5 shadow not live", rd_data, {4'h0, snap[11:8]});
        chk(m[11:8] != snap[11:8], "R5 live moved", m[11:8], snap[11:8]);

        // R3: difference across the wrap
        while (m != 12'hF00) @(negedge clk);
        do_read(lo, hi, snap);
        r1 = {hi[3:0], lo};
        chk(r1 == snap, "R3 first", r1, snap);
        repeat (4000) @(negedge clk);
        do_read(lo, hi, snap);
        r2 = {hi[3:0], lo};
        chk(r2 < r1, "R3 wrapped", r2, r1);
        chk(12'(r2 - r1) == 12'd4002, "R3 diff", 12'(r2 - r1), 4002);

        // R8 R9: ticks against the reference count
        mis = 0; frise = 0; fcnt = 0; srise = 0; scnt = 0;
        for (int i = 0; i < 2100; i++) begin
            en = (i < 1500) ? 1'b1 : i[0];
            @(negedge clk);
            if (tf != (m[6] & ~mp[6])) mis++;
            if (ts != (m[9] & ~mp[9])) mis++;
            if (m[6] & ~mp[6]) frise++;
            if (m[9] & ~mp[9]) srise++;
            if (tf) fcnt++;
            if (ts) scnt++;
        end
        en = 1'b0;
        chk(mis == 0, "R8 R9 per-cycle", mis, 0);
        chk(fcnt == frise && fcnt >= 10, "R8 count", fcnt, frise);
        chk(scnt == srise && scnt >= 1, "R9 count", scnt, srise);
        @(negedge clk);
        chk(!tf && !ts, "R8 idle", {tf, ts}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule